// File: doc/BRIEF.md
# Word-to-Byte-Pair Access Sequencer

This block sits between a 16-bit processor bus and an 8-bit target that cannot take a 16-bit word in a single cycle. A request whose active-low size input is low is carried out as two consecutive byte accesses: the even byte first, then the odd byte at the next address. Each byte gets its own read or write strobe. A request whose size input is high is a plain byte access and produces a single strobe.

On a word write, the block places the low half of the write word on the 8-bit lane for the first access and the high half for the second. On a word read, the first byte goes into a holding register. The assembled word is presented together with the completion pulse after the second byte arrives. The processor sees a wait output that stays high for the whole sequence.

The target may stretch any strobe by holding its wait input high. All timing is counted in clock cycles, so the sequence does not depend on the clock rate.

The request side uses a simple valid/ready handshake. A request is taken on a rising edge where `cpu_req_valid` and `cpu_ready` are both high. `cpu_ready` is high only while the block is idle, so back-pressure lasts for the whole transfer. Address, size, direction and write data are sampled only at acceptance.

Top module: `pair_byte_seq`

## Requirements
- R1: After synchronous reset the block is idle: `cpu_ready`=1, `cpu_wait`=0, `cpu_done`=0, `per_rd`=0, `per_wr`=0.
- R2: A request with `cpu_size_n`=1 makes exactly one target access at `cpu_addr`. A write drives `cpu_wdata[7:0]` on the lane. A read returns `{8'h00, byte}` on `cpu_rdata`.
- R3: A request with `cpu_size_n`=0 makes exactly two target accesses. The first is at `cpu_addr` with bit 0 cleared and the second at `cpu_addr` with bit 0 set, whatever the request's bit 0 was.
- R4: On a word read, `cpu_rdata[7:0]` holds the byte from the first access and `cpu_rdata[15:8]` the byte from the second. The word is valid while `cpu_done`=1.
- R5: On a word write, the first access carries `cpu_wdata[7:0]` and the second carries `cpu_wdata[15:8]`.
- R6: Address and lane data are set up at least one cycle before a strobe rises and do not change while the strobe is high. The strobe is low for at least one cycle after each byte completes.
- R7: A strobe stays high while `per_wait`=1, and the byte completes on the first strobe cycle with `per_wait`=0. Counting edges after the acceptance edge, `cpu_done` rises after 2+w edges for a byte and 4+w0+w1 edges for a word, where w is the number of wait cycles on a byte.
- R8: `cpu_wait` is 1 from the cycle after acceptance until the transfer completes, and is 0 while `cpu_done`=1.
- R9: `cpu_done` is a one-cycle pulse, followed by `cpu_ready`=1. Request inputs that change, or a held `cpu_req_valid`, while the block is busy have no effect on the transfer in progress.
- R10: A read raises only `per_rd` and a write raises only `per_wr`; the two never rise together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req_valid | input | 1 | Request valid |
| cpu_ready | output | 1 | Block idle and able to accept a request |
| cpu_size_n | input | 1 | Transfer size, low = 16-bit word, high = byte |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 16 | Write word (bits 7:0 are used for a byte write) |
| cpu_wait | output | 1 | Processor held in wait during the transfer |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 16 | Read result, valid with cpu_done |
| per_addr | output | ADDR_W | Target byte address |
| per_wdata | output | 8 | Target write lane |
| per_rdata | input | 8 | Target read lane |
| per_rd | output | 1 | Target read strobe, active high |
| per_wr | output | 1 | Target write strobe, active high |
| per_wait | input | 1 | Target wait request, active high |

## Verification
The assertions assume that `per_wait` only matters while a strobe is high and that the target releases it after a bounded number of cycles. They also assume that `rst` is held high from time zero until the first clock edges. The bench's target model raises wait only while a strobe is high, for a programmed count of 0, 1 or 3 cycles per byte. The bench drives reset from the first instant. Request inputs are deliberately scrambled while the block is busy, which stays within the handshake rules because `cpu_ready` is low for that whole time.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_BYTE0 = 3'd1,
    ST_GAP   = 3'd2,
    ST_BYTE1 = 3'd3,
    ST_DONE  = 3'd4
  } pbs_state_t;
endpackage

// File: rtl/pbs_ctrl.sv
module pbs_ctrl
  import pbs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic req_word,
  input  logic req_write,
  input  logic per_wait,
  output logic accept,
  output logic strobe,
  output logic rd_stb,
  output logic wr_stb,
  output logic lane_hi,
  output logic cap_lo,
  output logic cap_hi,
  output logic cpu_ready,
  output logic cpu_wait,
  output logic cpu_done
);
  pbs_state_t state_q, state_d;
  logic setup_q, setup_d;
  logic word_q, write_q;
  logic complete;

  assign cpu_ready = (state_q == ST_IDLE);
  assign accept    = cpu_ready && req_valid;
  assign strobe    = ((state_q == ST_BYTE0) && !setup_q) || (state_q == ST_BYTE1);
  assign complete  = strobe && !per_wait;
  assign rd_stb    = strobe && !write_q;
  assign wr_stb    = strobe && write_q;
  assign lane_hi   = (state_q == ST_GAP) || (state_q == ST_BYTE1);
  assign cap_lo    = (state_q == ST_BYTE0) && complete;
  assign cap_hi    = (state_q == ST_BYTE1) && complete;
  assign cpu_wait  = (state_q == ST_BYTE0) || (state_q == ST_GAP) || (state_q == ST_BYTE1);
  assign cpu_done  = (state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    setup_d = setup_q;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        state_d = ST_BYTE0;
        setup_d = 1'b1;
      end
      ST_BYTE0: begin
        if (setup_q) setup_d = 1'b0;
        else if (complete) state_d = word_q ? ST_GAP : ST_DONE;
      end
      ST_GAP:   state_d = ST_BYTE1;
      ST_BYTE1: if (complete) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      setup_q <= 1'b0;
      word_q  <= 1'b0;
      write_q <= 1'b0;
    end else begin
      state_q <= state_d;
      setup_q <= setup_d;
      if (accept) begin
        word_q  <= req_word;
        write_q <= req_write;
      end
    end
  end

  // R8
  wait_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> cpu_wait);
  // R6
  gap_after_byte_chk: assert property (@(posedge clk) disable iff (rst)
    complete |=> !strobe);
  // R9
  done_then_ready_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> cpu_ready && !cpu_done);
endmodule

// File: rtl/pbs_datapath.sv
module pbs_datapath #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                accept,
  input  logic                req_word,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [2*BYTE_W-1:0] cpu_wdata,
  input  logic                lane_hi,
  input  logic                cap_lo,
  input  logic                cap_hi,
  input  logic [BYTE_W-1:0]   per_rdata,
  output logic [ADDR_W-1:0]   per_addr,
  output logic [BYTE_W-1:0]   per_wdata,
  output logic [2*BYTE_W-1:0] cpu_rdata
);
  localparam int WORD_W = 2 * BYTE_W;

  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wd_q;
  logic [BYTE_W-1:0] lo_q, hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      wd_q   <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      if (accept) begin
        addr_q <= req_word ? {cpu_addr[ADDR_W-1:1], 1'b0} : cpu_addr;
        wd_q   <= cpu_wdata;
        hi_q   <= '0;
      end
      if (cap_lo) lo_q <= per_rdata;
      if (cap_hi) hi_q <= per_rdata;
    end
  end

  assign per_addr  = lane_hi ? {addr_q[ADDR_W-1:1], 1'b1} : addr_q;
  assign per_wdata = lane_hi ? wd_q[WORD_W-1:BYTE_W] : wd_q[BYTE_W-1:0];
  assign cpu_rdata = {hi_q, lo_q};
endmodule

// File: rtl/pair_byte_seq.sv
module pair_byte_seq #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req_valid,
  output logic              cpu_ready,
  input  logic              cpu_size_n,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [15:0]       cpu_wdata,
  output logic              cpu_wait,
  output logic              cpu_done,
  output logic [15:0]       cpu_rdata,
  output logic [ADDR_W-1:0] per_addr,
  output logic [7:0]        per_wdata,
  input  logic [7:0]        per_rdata,
  output logic              per_rd,
  output logic              per_wr,
  input  logic              per_wait
);
  localparam int BYTE_W = 8;

  logic accept, strobe, lane_hi, cap_lo, cap_hi;

  pbs_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_valid (cpu_req_valid),
    .req_word  (!cpu_size_n),
    .req_write (cpu_write),
    .per_wait  (per_wait),
    .accept    (accept),
    .strobe    (strobe),
    .rd_stb    (per_rd),
    .wr_stb    (per_wr),
    .lane_hi   (lane_hi),
    .cap_lo    (cap_lo),
    .cap_hi    (cap_hi),
    .cpu_ready (cpu_ready),
    .cpu_wait  (cpu_wait),
    .cpu_done  (cpu_done)
  );

  pbs_datapath #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .req_word  (!cpu_size_n),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .lane_hi   (lane_hi),
    .cap_lo    (cap_lo),
    .cap_hi    (cap_hi),
    .per_rdata (per_rdata),
    .per_addr  (per_addr),
    .per_wdata (per_wdata),
    .cpu_rdata (cpu_rdata)
  );

  // R6
  setup_before_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(strobe) |-> $stable(per_addr) && $stable(per_wdata));
  // R7
  hold_in_wait_chk: assert property (@(posedge clk) disable iff (rst)
    strobe && per_wait |=> strobe && $stable(per_addr) && $stable(per_wdata));
  // R8
  no_wait_at_done_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> !cpu_wait && !per_rd && !per_wr);
  // R10
  single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !(per_rd && per_wr));
endmodule

// File: tb/pair_byte_seq_bench.sv
`timescale 1ns/1ps
module pair_byte_seq_bench;
  localparam int AW = 4;
  localparam int NB = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_req_valid = 1'b0, cpu_size_n = 1'b1, cpu_write = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic cpu_ready, cpu_wait, cpu_done, per_rd, per_wr, per_wait;
  logic [15:0] cpu_rdata;
  logic [AW-1:0] per_addr;
  logic [7:0] per_wdata, per_rdata;

  int checks = 0, errors = 0;
  int w0 = 0, w1 = 0;
  int age, nstr;
  logic [7:0] mem [NB];
  logic [7:0] model [NB];
  logic [AW-1:0] la [2];
  logic [7:0] lw [2];
  logic lk [2];

  always #10 clk = ~clk;

  pair_byte_seq #(.ADDR_W(AW)) u_pair_byte_seq (
    .clk(clk), .rst(rst), .cpu_req_valid(cpu_req_valid), .cpu_ready(cpu_ready),
    .cpu_size_n(cpu_size_n), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_wait(cpu_wait), .cpu_done(cpu_done),
    .cpu_rdata(cpu_rdata), .per_addr(per_addr), .per_wdata(per_wdata),
    .per_rdata(per_rdata), .per_rd(per_rd), .per_wr(per_wr), .per_wait(per_wait)
  );

  // target model: wait count per byte, memory of NB bytes
  assign per_wait  = (per_rd || per_wr) && (age < ((nstr == 0) ? w0 : w1));
  assign per_rdata = per_rd ? mem[per_addr] : 8'h5A;

  always_ff @(posedge clk) begin
    if (rst) begin
      age  <= 0;
      nstr <= 0;
      for (int i = 0; i < NB; i++) mem[i] <= 8'((i * 37 + 5) & 255);
    end else begin
      if (cpu_req_valid && cpu_ready) nstr <= 0;
      else if ((per_rd || per_wr) && !per_wait) begin
        if (nstr < 2) begin
          la[nstr] <= per_addr;
          lw[nstr] <= per_wdata;
          lk[nstr] <= per_wr;
        end
        nstr <= nstr + 1;
        if (per_wr) mem[per_addr] <= per_wdata;
      end
      age <= ((per_rd || per_wr) && per_wait) ? age + 1 : 0;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic word, input int a,
                      input logic [15:0] wd, input int wa, input int wb);
    int cnt, exp_lat, ea0, ea1;
    logic [15:0] exp_rd;
    @(negedge clk);
    w0 = wa; w1 = wb;
    cpu_req_valid = 1'b1; cpu_size_n = !word; cpu_write = wr;
    cpu_addr = AW'(a); cpu_wdata = wd;
    chk(cpu_ready == 1'b1, "R9 ready before request", int'(cpu_ready), 1);
    ea0 = word ? (a & ~1) : a;
    ea1 = a | 1;
    exp_rd = word ? {model[ea1], model[ea0]} : {8'h00, model[ea0]};
    @(negedge clk);
    // R9: scrambled inputs and held valid while busy
    cpu_addr = ~cpu_addr; cpu_wdata = ~cpu_wdata; cpu_write = ~cpu_write;
    cpu_size_n = ~cpu_size_n;
    cnt = 1;
    while (!cpu_done && cnt < 100) begin
      chk(cpu_wait == 1'b1, "R8 wait while busy", int'(cpu_wait), 1);
      @(negedge clk);
      cnt++;
    end
    cpu_req_valid = 1'b0;
    exp_lat = word ? (5 + wa + wb) : (3 + wa);
    chk(cnt == exp_lat, "R7 latency", cnt, exp_lat);
    chk(cpu_wait == 1'b0, "R8 wait low at done", int'(cpu_wait), 0);
    chk(nstr == (word ? 2 : 1), word ? "R3 two accesses" : "R2 one access",
        nstr, word ? 2 : 1);
    chk(int'(la[0]) == ea0, "R3 first address", int'(la[0]), ea0);
    chk(lk[0] == wr, "R10 strobe kind", int'(lk[0]), int'(wr));
    if (word) begin
      chk(int'(la[1]) == ea1, "R3 second address", int'(la[1]), ea1);
      chk(lk[1] == wr, "R10 strobe kind", int'(lk[1]), int'(wr));
    end
    if (wr) begin
      chk(lw[0] == wd[7:0], word ? "R5 low lane" : "R2 byte lane",
          int'(lw[0]), int'(wd[7:0]));
      model[ea0] = wd[7:0];
      if (word) begin
        chk(lw[1] == wd[15:8], "R5 high lane", int'(lw[1]), int'(wd[15:8]));
        model[ea1] = wd[15:8];
      end
    end else begin
      chk(cpu_rdata == exp_rd, word ? "R4 word assembly" : "R2 byte read",
          int'(cpu_rdata), int'(exp_rd));
    end
    @(negedge clk);
    chk(cpu_done == 1'b0 && cpu_ready == 1'b1, "R9 done pulse then ready",
        int'({cpu_done, cpu_ready}), 1);
    for (int i = 0; i < NB; i++)
      chk(mem[i] == model[i], "R9 target contents", int'(mem[i]), int'(model[i]));
  endtask

  initial begin
    for (int i = 0; i < NB; i++) model[i] = 8'((i * 37 + 5) & 255);
    repeat (3) @(negedge clk);
    chk(cpu_ready && !cpu_wait && !cpu_done && !per_rd && !per_wr, "R1 reset state",
        int'({cpu_ready, cpu_wait, cpu_done, per_rd, per_wr}), 16);
    rst = 1'b0;
    @(negedge clk);
    chk(cpu_ready && !per_rd && !per_wr, "R1 idle after reset",
        int'({cpu_ready, per_rd, per_wr}), 4);
    for (int a = 0; a < NB; a++)
      for (int sz = 0; sz < 2; sz++)
        for (int dir = 0; dir < 2; dir++)
          for (int wi = 0; wi < 9; wi++) begin
            int wa = (wi % 3 == 2) ? 3 : wi % 3;
            int wb = (wi / 3 == 2) ? 3 : wi / 3;
            logic [15:0] wd = 16'((a * 4099 + wi * 771 + sz * 97 + 16'h1234) & 16'hFFFF);
            xfer(dir[0], sz[0], a, wd, wa, wb);
          end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule